// File: doc/BRIEF.md
# Retention-Binned Multi-Rate Refresh Scheduler

This block decides, row by row, which DRAM rows a memory controller must refresh during each pass. A round timer starts a pass over every row address. For each row the block checks two compact membership filters, one for short-retention rows and one for medium-retention rows, and uses the hit to place the row in a retention class. Each class has its own rate. Short-retention rows are refreshed on every pass. Medium rows are refreshed on every second pass. Rows found in neither filter are refreshed on every fourth pass. When one pass takes 64 ms, the three classes get 64 ms, 128 ms and 256 ms periods.

The filters are loaded during a profiling phase through an insert port, which takes a row address and a class select. A synchronous clear input empties both filters. When a row is due for refresh, the block raises a request carrying the row address and its class, and it holds that request until the downstream command scheduler acknowledges it. Each filter sets two bits per inserted row. A filter can report a false hit, but a false hit can only move a row to a faster class.

Top module: `multirate_refresh_sched`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `ref_req` is 0 and `ref_round` is 0.
- R2: A pass looks up rows 0 through 2^ROW_W-1 in ascending order, once each. Requests therefore come out in ascending row order. At the end of each pass `ref_round` (2 bits) advances by one, wrapping from 3 to 0.
- R3: A row in the short filter is requested on every pass, with `ref_class` = 0.
- R4: A row in the medium filter only is requested only while `ref_round` is 0 or 2, with `ref_class` = 1.
- R5: A row in neither filter is requested only while `ref_round` is 0, with `ref_class` = 2.
- R6: A row that hits both filters is treated as short, with `ref_class` = 0.
- R7: Inserting a row sets two bits of the selected 256-bit filter (`ins_bin` 0 = short filter, 1 = medium filter). The first bit index is the XOR of the row address's 8-bit slices, with the upper slice zero-padded. The second bit index is bits [9:2] of (row × 567) mod 1024. A row hits a filter when both of its bits are set.
- R8: `ref_req` stays high, with `ref_row` and `ref_class` unchanged, until `ref_ack` is sampled high. A row that is not due takes one cycle. A due row takes its lookup cycle plus its request cycles.
- R9: One cycle of `filt_clr` empties both filters. After a clear, every row falls in the default class.
- R10: A pass starts each time the round timer completes `round_period` cycles. After reset, the first lookup happens in cycle `round_period`+1 and the first request is visible after cycle `round_period`+2. If the timer expires during a pass, the next pass starts as soon as the current one ends.
- R11: An insert applies to every lookup from the next cycle on, including lookups later in the pass that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| filt_clr | input | 1 | Synchronous clear of both filters |
| ins_valid | input | 1 | Profiling insert strobe |
| ins_row | input | ROW_W | Row address to insert |
| ins_bin | input | 1 | Filter select: 0 short, 1 medium |
| round_period | input | PER_W | Cycles per pass start |
| ref_ack | input | 1 | Scheduler accepts the current request |
| ref_req | output | 1 | Refresh request |
| ref_row | output | ROW_W | Row to refresh |
| ref_class | output | 2 | Class of that row: 0 short, 1 medium, 2 default |
| ref_round | output | 2 | Pass index modulo 4 |

## Verification
A corrupted filter bit, a wrong class priority or a wrong round count does not stay hidden. It shows up at the first affected row of the next pass, as a missing request, an extra request or a wrong `ref_class`. With a pass every few thousand cycles, such a fault appears within one or two passes. A walker that skips or repeats a row breaks the ascending order of `ref_row` within a single pass. A stray advance while `ref_ack` is low changes `ref_row` in the very next cycle. A timer that is off by one moves the first request away from cycle `round_period`+2.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    localparam int RND_W = 2;

    typedef enum logic [1:0] {
        CLS_FAST = 2'd0,
        CLS_MID  = 2'd1,
        CLS_SLOW = 2'd2
    } rclass_e;

    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_LOOK = 2'd1,
        WK_REQ  = 2'd2
    } wstate_e;

    // Short filter outranks medium: a false hit can only speed a row up.
    function automatic rclass_e pick_class(input logic hit_fast, input logic hit_mid);
        if (hit_fast)
            return CLS_FAST;
        else if (hit_mid)
            return CLS_MID;
        else
            return CLS_SLOW;
    endfunction

    function automatic logic class_due(input rclass_e c, input logic [RND_W-1:0] rnd);
        case (c)
            CLS_FAST: return 1'b1;
            CLS_MID:  return ~rnd[0];
            default:  return (rnd == '0);
        endcase
    endfunction

endpackage

// File: rtl/rrs_bloom_bin.sv
module rrs_bloom_bin #(
    parameter int ROW_W = 10,
    parameter int IDX_W = 8,
    parameter int MUL   = 567
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ins_en,
    input  logic [ROW_W-1:0] ins_row,
    input  logic [ROW_W-1:0] look_row,
    output logic             hit
);
    localparam int NBITS = 1 << IDX_W;
    localparam int NCH   = (ROW_W + IDX_W - 1) / IDX_W;

    function automatic logic [IDX_W-1:0] fold_idx(input logic [ROW_W-1:0] r);
        logic [NCH*IDX_W-1:0] ext;
        logic [IDX_W-1:0]     acc;
        ext = '0;
        ext[ROW_W-1:0] = r;
        acc = '0;
        for (int i = 0; i < NCH; i++)
            acc ^= ext[i*IDX_W +: IDX_W];
        return acc;
    endfunction

    function automatic logic [IDX_W-1:0] mul_idx(input logic [ROW_W-1:0] r);
        logic [ROW_W-1:0] p;
        p = r * ROW_W'(MUL);
        return p[ROW_W-1 -: IDX_W];
    endfunction

    logic [NBITS-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bits_q <= '0;
        end else if (ins_en) begin
            bits_q[fold_idx(ins_row)] <= 1'b1;
            bits_q[mul_idx(ins_row)]  <= 1'b1;
        end
    end

    assign hit = bits_q[fold_idx(look_row)] & bits_q[mul_idx(look_row)];

endmodule

// File: rtl/rrs_round_timer.sv
module rrs_round_timer #(
    parameter int PER_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period,
    output logic             fire
);
    logic [PER_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = ({1'b0, cnt_q} + 1'b1) >= {1'b0, period};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            fire  <= 1'b0;
        end else begin
            fire  <= wrap;
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rrs_row_walker.sv
module rrs_row_walker
    import rrs_pkg::*;
#(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             hit_fast,
    input  logic             hit_mid,
    input  logic             ack,
    output logic [ROW_W-1:0] row,
    output rclass_e          cls,
    output logic             req,
    output logic [RND_W-1:0] rnd
);
    localparam logic [ROW_W-1:0] LAST_ROW = '1;

    wstate_e          st_q;
    logic [ROW_W-1:0] row_q;
    rclass_e          cls_q;
    logic [RND_W-1:0] rnd_q;
    logic             pend_q;
    rclass_e          look_cls;
    logic             look_due;
    logic             step;

    assign look_cls = pick_class(hit_fast, hit_mid);
    assign look_due = class_due(look_cls, rnd_q);
    assign step     = ((st_q == WK_LOOK) && !look_due) || ((st_q == WK_REQ) && ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= WK_IDLE;
            row_q  <= '0;
            cls_q  <= CLS_FAST;
            rnd_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= (st_q == WK_IDLE) ? 1'b0 : (pend_q | start);
            case (st_q)
                WK_IDLE: if (start || pend_q) begin
                    st_q  <= WK_LOOK;
                    row_q <= '0;
                end
                WK_LOOK: if (look_due) begin
                    st_q  <= WK_REQ;
                    cls_q <= look_cls;
                end
                default: ;
            endcase
            if (step) begin
                if (row_q == LAST_ROW) begin
                    row_q <= '0;
                    rnd_q <= rnd_q + 1'b1;
                    st_q  <= WK_IDLE;
                end else begin
                    row_q <= row_q + 1'b1;
                    st_q  <= WK_LOOK;
                end
            end
        end
    end

    assign row = row_q;
    assign cls = cls_q;
    assign req = (st_q == WK_REQ);
    assign rnd = rnd_q;

endmodule

// File: rtl/multirate_refresh_sched.sv
module multirate_refresh_sched
    import rrs_pkg::*;
#(
    parameter int ROW_W    = 10,
    parameter int IDX_W    = 8,
    parameter int PER_W    = 24,
    parameter int HASH_MUL = 567
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             filt_clr,
    input  logic             ins_valid,
    input  logic [ROW_W-1:0] ins_row,
    input  logic             ins_bin,
    input  logic [PER_W-1:0] round_period,
    input  logic             ref_ack,
    output logic             ref_req,
    output logic [ROW_W-1:0] ref_row,
    output logic [1:0]       ref_class,
    output logic [RND_W-1:0] ref_round
);
    localparam int NBINS = 2;

    logic [NBINS-1:0] bin_hit;
    logic             tick;
    rclass_e          wk_cls;

    for (genvar b = 0; b < NBINS; b++) begin : g_bin
        rrs_bloom_bin #(
            .ROW_W (ROW_W),
            .IDX_W (IDX_W),
            .MUL   (HASH_MUL)
        ) u_bin (
            .clk      (clk),
            .rst      (rst),
            .clr      (filt_clr),
            .ins_en   (ins_valid && (ins_bin == b[0])),
            .ins_row  (ins_row),
            .look_row (ref_row),
            .hit      (bin_hit[b])
        );
    end

    rrs_round_timer #(.PER_W(PER_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .period (round_period),
        .fire   (tick)
    );

    rrs_row_walker #(.ROW_W(ROW_W)) u_walk (
        .clk      (clk),
        .rst      (rst),
        .start    (tick),
        .hit_fast (bin_hit[0]),
        .hit_mid  (bin_hit[1]),
        .ack      (ref_ack),
        .row      (ref_row),
        .cls      (wk_cls),
        .req      (ref_req),
        .rnd      (ref_round)
    );

    assign ref_class = wk_cls;

endmodule

// File: rtl/rrs_checks.sv
module rrs_checks #(
    parameter int ROW_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             filt_clr,
    input logic             ref_req,
    input logic             ref_ack,
    input logic [ROW_W-1:0] ref_row,
    input logic [1:0]       ref_class,
    input logic [1:0]       ref_round,
    input logic [1:0]       bin_hit
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!ref_req && ref_round == 2'd0));

    assert_round_step_R2: assert property (@(posedge clk) disable iff (rst)
        (ref_round != $past(ref_round)) |-> (ref_round == $past(ref_round) + 2'd1));

    assert_class_legal_R3: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> (ref_class != 2'd3));

    assert_mid_even_R4: assert property (@(posedge clk) disable iff (rst)
        (ref_req && ref_class == 2'd1) |-> !ref_round[0]);

    assert_slow_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (ref_req && ref_class == 2'd2) |-> (ref_round == 2'd0));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (ref_req && !ref_ack) |=> (ref_req && $stable(ref_row) && $stable(ref_class)));

    assert_one_req_R8: assert property (@(posedge clk) disable iff (rst)
        (ref_req && ref_ack) |=> !ref_req);

    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (rst)
        filt_clr |=> (bin_hit == 2'b00));

endmodule

bind multirate_refresh_sched rrs_checks #(.ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .filt_clr  (filt_clr),
    .ref_req   (ref_req),
    .ref_ack   (ref_ack),
    .ref_row   (ref_row),
    .ref_class (ref_class),
    .ref_round (ref_round),
    .bin_hit   (bin_hit)
);

// File: tb/multirate_refresh_sched_test.sv
`timescale 1ns/1ps
module multirate_refresh_sched_test;
    localparam int NROWS = 1024;
    localparam int PER   = 2500;
    localparam int NV    = 9;
    // {bin, row}
    localparam logic [10:0] TBL [NV] = '{
        {1'b0, 10'd3},   {1'b0, 10'd77},  {1'b1, 10'd512},
        {1'b1, 10'd900}, {1'b0, 10'd5},   {1'b1, 10'd5},
        {1'b1, 10'd1023},{1'b0, 10'd0},   {1'b1, 10'd640}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        filt_clr = 1'b0;
    logic        ins_valid = 1'b0;
    logic [9:0]  ins_row = '0;
    logic        ins_bin = 1'b0;
    logic [23:0] round_period = 24'(PER);
    logic        ref_ack = 1'b1;
    logic        ref_req;
    logic [9:0]  ref_row;
    logic [1:0]  ref_class;
    logic [1:0]  ref_round;

    always #10 clk = ~clk;

    multirate_refresh_sched uut (
        .clk(clk), .rst(rst), .filt_clr(filt_clr), .ins_valid(ins_valid),
        .ins_row(ins_row), .ins_bin(ins_bin), .round_period(round_period),
        .ref_ack(ref_ack), .ref_req(ref_req), .ref_row(ref_row),
        .ref_class(ref_class), .ref_round(ref_round)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [255:0] m_fast = '0;
    logic [255:0] m_mid  = '0;
    int mptr = 0, mround = 0, hs_total = 0, first_cyc = -1, clr_hs = 0;
    bit after_clr = 0, seen1000 = 0;
    int cnt [NROWS];

    always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    function automatic logic [7:0] hx(input logic [9:0] r);
        return r[7:0] ^ {6'b0, r[9:8]};
    endfunction

    function automatic logic [7:0] hm(input logic [9:0] r);
        logic [19:0] p;
        p = r * 20'd567;
        return p[9:2];
    endfunction

    function automatic int mcls(input int r);
        logic [9:0] a;
        a = r[9:0];
        if (m_fast[hx(a)] && m_fast[hm(a)]) return 0;
        if (m_mid[hx(a)] && m_mid[hm(a)]) return 1;
        return 2;
    endfunction

    function automatic bit mdue(input int c, input int rnd);
        return (c == 0) || (c == 1 && (rnd % 2) == 0) || (c == 2 && (rnd % 4) == 0);
    endfunction

    // Reference monitor: every completed handshake must be the next due row.
    always @(negedge clk) begin
        if (!rst && ref_req && ref_ack) begin
            int ec;
            string tg;
            while (!mdue(mcls(mptr), mround)) begin
                mptr++;
                if (mptr == NROWS) begin mptr = 0; mround++; end
            end
            ec = mcls(mptr);
            tg = (ec == 0) ? "R3/R7" : (ec == 1) ? "R4/R7" : "R5/R2";
            chk(ref_row == 10'(mptr) && ref_class == 2'(ec) && ref_round == 2'(mround % 4), tg,
                $sformatf("row/class/round act %0d/%0d/%0d exp %0d/%0d/%0d",
                          ref_row, ref_class, ref_round, mptr, ec, mround % 4));
            if (mround < 4) cnt[mptr]++;
            if (mptr == 1000 && mround == 5 && ec == 0) seen1000 = 1;
            if (first_cyc < 0) first_cyc = cyc;
            if (after_clr && (ref_round == 2'd2 || ref_round == 2'd3)) clr_hs++;
            hs_total++;
            mptr++;
            if (mptr == NROWS) begin mptr = 0; mround++; end
        end
    end

    task automatic do_insert(input logic [9:0] r, input logic b);
        @(posedge clk); #2;
        ins_valid = 1'b1; ins_row = r; ins_bin = b;
        if (b) begin m_mid[hx(r)] = 1'b1; m_mid[hm(r)] = 1'b1; end
        else   begin m_fast[hx(r)] = 1'b1; m_fast[hm(r)] = 1'b1; end
        @(posedge clk); #2;
        ins_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NROWS; i++) cnt[i] = 0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk(ref_req == 1'b0 && ref_round == 2'd0, "R1",
            $sformatf("req/round act %0d/%0d exp 0/0", ref_req, ref_round));

        for (int i = 0; i < NV; i++) do_insert(TBL[i][9:0], TBL[i][10]);

        while (first_cyc < 0) @(negedge clk);
        chk(first_cyc == PER + 2, "R10",
            $sformatf("first request cycle act %0d exp %0d", first_cyc, PER + 2));

        while (mround < 4) @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            int r, ec, ex;
            r  = int'(TBL[i][9:0]);
            ec = mcls(r);
            ex = (ec == 0) ? 4 : (ec == 1) ? 2 : 1;
            chk(cnt[r] == ex, (r == 5) ? "R6" : (TBL[i][10] ? "R4" : "R3"),
                $sformatf("row %0d refreshes over 4 passes act %0d exp %0d", r, cnt[r], ex));
        end
        chk(mcls(5) == 0, "R6", $sformatf("row 5 class act %0d exp 0", mcls(5)));

        // R8: stall the acknowledge in pass 4 (every row due)
        while (cyc < 5 * PER + 60) @(negedge clk);
        @(posedge clk); #2 ref_ack = 1'b0;
        do @(negedge clk); while (!ref_req);
        begin
            logic [9:0] held_row;
            logic [1:0] held_cls;
            held_row = ref_row;
            held_cls = ref_class;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                chk(ref_req && ref_row == held_row && ref_class == held_cls, "R8",
                    $sformatf("stall req/row act %0d/%0d exp 1/%0d", ref_req, ref_row, held_row));
            end
        end
        @(posedge clk); #2 ref_ack = 1'b1;

        // R11: insert mid-pass, well ahead of the walker, during pass 5
        while (cyc < 6 * PER + 300) @(negedge clk);
        chk(ref_round == 2'd1, "R2", $sformatf("round in pass 5 act %0d exp 1", ref_round));
        do_insert(10'd1000, 1'b0);
        while (ref_round != 2'd2) @(negedge clk);
        chk(seen1000, "R11", $sformatf("row 1000 refreshed in pass 5 act %0d exp 1", seen1000));

        // R9: clear between passes, then passes 6 and 7 must request nothing
        @(posedge clk); #2 filt_clr = 1'b1; m_fast = '0; m_mid = '0;
        @(posedge clk); #2 filt_clr = 1'b0; after_clr = 1;
        while (ref_round != 2'd0) @(negedge clk);
        chk(clr_hs == 0, "R9", $sformatf("requests in passes 6-7 act %0d exp 0", clr_hs));
        begin
            int base;
            base = hs_total;
            while (hs_total < base + 100) @(negedge clk);
        end
        chk(mround == 8, "R2", $sformatf("model pass act %0d exp 8", mround));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule